// File: doc/BRIEF.md
# Watchdog Countdown Timer

The block is a system watchdog. A prescaler divides the reference clock into a steady tick, ideally one per microsecond. A 24-bit down-counter steps on each tick. Software keeps the system alive by rewriting the load value before the counter runs out. If the counter runs out, or software forces a trigger, the block sends a one-cycle reset request to a chosen set of reset domains.

Configuration uses plain write strobes, one per register: the prescaler setup, the control word, the load value and the domain mask. Counting stops while the enable bit is clear. Counting also stops while any pause source is both enabled in the control word and active on its status input. There are three pause sources: a debug halt on either of two processors, and debug-probe bus access. The counter drops by two on every tick. Software therefore loads twice the wanted number of ticks.

Top module: `wdog_timer`

## Requirements
- R1: After reset, ctrl_o reads 5'b01110 (enable clear, all three pause bits set). count_o is 0, rst_req_o is 0 and tick_o is 0. The prescaler is off and the domain mask is all ones.
- R2: A prescaler write with enable 1 and cycles N≥1 makes tick_o go high for one cycle. This happens first on the Nth clock edge after the write, then on every Nth edge after that. A cycles value of 0 behaves as 1.
- R3: While the prescaler enable is 0, tick_o stays low.
- R4: A step happens on the clock edge that ends a cycle in which all of these hold: tick_o is high, enable is set, no pause applies and the count is nonzero. On a step, count_o drops by 2, or becomes 0 if it was 1 or 2.
- R5: A load write places load_data_i in count_o at the next edge. A load write takes priority over a step in the same cycle.
- R6: Control bits 1, 2 and 3 enable pausing on dbg_halt0_i, dbg_halt1_i and jtag_busy_i in that order. The count holds while any enabled source is active. An active source whose pause bit is clear has no effect.
- R7: A step that leaves the count at 0 drives rst_req_o to the domain mask for exactly one cycle. This includes a step from 1. The count then stays at 0 until the next load write. It never wraps.
- R8: A control write with bit 4 set drives rst_req_o to the domain mask for one cycle after the write. This happens regardless of enable or count.
- R9: Control bit 0 is the enable. Bit 4 (trigger) is never stored, and ctrl_o[4] always reads 0.
- R10: A mask write replaces the domain mask. The request vector is exactly the mask. A domain whose bit is clear never sees a request.
- R11: With enable clear, the count holds whatever the tick activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_wr_i | input | 1 | Prescaler write strobe |
| tick_en_i | input | 1 | Prescaler enable value |
| tick_cycles_i | input | 8 | Reference cycles per tick |
| ctrl_wr_i | input | 1 | Control write strobe |
| ctrl_wdata_i | input | 5 | Control word: [0] enable, [3:1] pause enables, [4] trigger |
| load_wr_i | input | 1 | Load (feed) write strobe |
| load_data_i | input | 24 | Load value |
| rsel_wr_i | input | 1 | Domain mask write strobe |
| rsel_data_i | input | 17 | Domain mask value |
| dbg_halt0_i | input | 1 | Processor 0 halted in debug |
| dbg_halt1_i | input | 1 | Processor 1 halted in debug |
| jtag_busy_i | input | 1 | Debug probe accessing the bus |
| tick_o | output | 1 | Prescaler tick pulse |
| count_o | output | 24 | Current count |
| ctrl_o | output | 5 | Control readback, bit 4 always 0 |
| rst_req_o | output | 17 | One-cycle reset request per domain |

## Verification
The bench loads odd values to force a step from 1. A design that wraps would show a huge count and fire a second time later. It puts a load write in the same cycle as a step and as an expiry. A design with the wrong priority would lose the feed or raise a false reset. It raises a pause source whose pause bit is clear, which exposes a design that ignores the pause qualifier. It also fires the trigger with the counter disabled and with a narrow mask. A design that gated the trigger with enable, or failed to apply the mask, would send requests to the wrong domains or none at all.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int CTRL_W     = 5;
  localparam int CTRL_EN    = 0;
  localparam int CTRL_PS_LO = 1;
  localparam int NUM_PAUSE  = 3;
  localparam int CTRL_TRIG  = CTRL_PS_LO + NUM_PAUSE;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int CYC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             en_i,
  input  logic [CYC_W-1:0] cycles_i,
  output logic             tick_o
);
  logic             en_q, tick_q;
  logic [CYC_W-1:0] cyc_q, cnt_q;
  logic [CYC_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + (CYC_W+1)'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      cyc_q  <= '0;
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (wr_i) begin
      en_q   <= en_i;
      cyc_q  <= cycles_i;
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (!en_q) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (cnt_inc >= {1'b0, cyc_q}) begin
      cnt_q  <= '0;   // cycles of 0 or 1 tick every edge
      tick_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_inc[CYC_W-1:0];
      tick_q <= 1'b0;
    end
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int NUM_DOM = 17
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [CTRL_W-1:0]  wdata_i,
  input  logic               rsel_wr_i,
  input  logic [NUM_DOM-1:0] rsel_i,
  input  logic [NUM_PAUSE-1:0] halt_i,
  output logic               run_o,
  output logic               trig_o,
  output logic [NUM_DOM-1:0] rsel_o,
  output logic [CTRL_W-1:0]  ctrl_o
);
  logic                 en_q;
  logic [NUM_PAUSE-1:0] pause_q, hold;
  logic [NUM_DOM-1:0]   rsel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      pause_q <= '1;
    end else if (wr_i) begin
      en_q    <= wdata_i[CTRL_EN];
      pause_q <= wdata_i[CTRL_PS_LO +: NUM_PAUSE];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rsel_q <= '1;
    else if (rsel_wr_i) rsel_q <= rsel_i;
  end

  for (genvar i = 0; i < NUM_PAUSE; i++) begin : g_hold
    assign hold[i] = pause_q[i] & halt_i[i];
  end

  assign run_o  = en_q & ~|hold;
  assign trig_o = wr_i & wdata_i[CTRL_TRIG];  // write-only, never stored
  assign rsel_o = rsel_q;
  assign ctrl_o = {1'b0, pause_q, en_q};
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             dec, low;

  assign dec      = tick_i & run_i & (|cnt_q);
  assign low      = cnt_q <= CNT_W'(2);
  assign expire_o = dec & low & ~load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (dec)    cnt_q <= low ? '0 : cnt_q - CNT_W'(2);  // saturate at 0
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int CYC_W   = 8,
  parameter int CNT_W   = 24,
  parameter int NUM_DOM = 17
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_wr_i,
  input  logic               tick_en_i,
  input  logic [CYC_W-1:0]   tick_cycles_i,
  input  logic               ctrl_wr_i,
  input  logic [CTRL_W-1:0]  ctrl_wdata_i,
  input  logic               load_wr_i,
  input  logic [CNT_W-1:0]   load_data_i,
  input  logic               rsel_wr_i,
  input  logic [NUM_DOM-1:0] rsel_data_i,
  input  logic               dbg_halt0_i,
  input  logic               dbg_halt1_i,
  input  logic               jtag_busy_i,
  output logic               tick_o,
  output logic [CNT_W-1:0]   count_o,
  output logic [CTRL_W-1:0]  ctrl_o,
  output logic [NUM_DOM-1:0] rst_req_o
);
  logic               tick, run, trig, expire;
  logic [NUM_DOM-1:0] rsel_q, req_q;

  wdog_prescaler #(.CYC_W(CYC_W)) u_pre (
    .clk_i, .rst_ni,
    .wr_i     (tick_wr_i),
    .en_i     (tick_en_i),
    .cycles_i (tick_cycles_i),
    .tick_o   (tick)
  );

  wdog_ctrl #(.NUM_DOM(NUM_DOM)) u_ctrl (
    .clk_i, .rst_ni,
    .wr_i      (ctrl_wr_i),
    .wdata_i   (ctrl_wdata_i),
    .rsel_wr_i (rsel_wr_i),
    .rsel_i    (rsel_data_i),
    .halt_i    ({jtag_busy_i, dbg_halt1_i, dbg_halt0_i}),
    .run_o     (run),
    .trig_o    (trig),
    .rsel_o    (rsel_q),
    .ctrl_o    (ctrl_o)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .tick_i     (tick),
    .run_i      (run),
    .load_i     (load_wr_i),
    .load_val_i (load_data_i),
    .cnt_o      (count_o),
    .expire_o   (expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= '0;
    else         req_q <= (expire | trig) ? rsel_q : '0;
  end

  assign tick_o    = tick;
  assign rst_req_o = req_q;
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
  parameter int CNT_W   = 24,
  parameter int NUM_DOM = 17
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               ctrl_wr_i,
  input logic [4:0]         ctrl_wdata_i,
  input logic               load_wr_i,
  input logic [CNT_W-1:0]   load_data_i,
  input logic               rsel_wr_i,
  input logic               dbg_halt0_i,
  input logic               dbg_halt1_i,
  input logic               jtag_busy_i,
  input logic [CNT_W-1:0]   count_o,
  input logic [4:0]         ctrl_o,
  input logic [NUM_DOM-1:0] rst_req_o,
  input logic [NUM_DOM-1:0] rsel_q
);
  logic paused, trig_wr;
  assign paused  = (ctrl_o[1] & dbg_halt0_i) | (ctrl_o[2] & dbg_halt1_i) | (ctrl_o[3] & jtag_busy_i);
  assign trig_wr = ctrl_wr_i & ctrl_wdata_i[4];

  AST_LOAD_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_wr_i |=> count_o == $past(load_data_i)); // R5
  AST_STEP_BY_TWO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_wr_i |=> (count_o == $past(count_o)) || (count_o == $past(count_o) - CNT_W'(2)) || (count_o == '0)); // R4
  AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == '0 && !load_wr_i) |=> count_o == '0); // R7
  AST_PAUSE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (paused && !load_wr_i) |=> $stable(count_o)); // R6
  AST_DISABLED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_o[0] && !load_wr_i) |=> $stable(count_o)); // R11
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|rst_req_o) && !trig_wr) |=> rst_req_o == '0); // R7
  AST_TRIG_FIRES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_wr |=> rst_req_o == $past(rsel_q)); // R8
  AST_REQ_IN_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsel_wr_i |=> (rst_req_o & ~rsel_q) == '0); // R10
endmodule

bind wdog_timer wdog_timer_chk #(.CNT_W(CNT_W), .NUM_DOM(NUM_DOM)) u_chk (
  .clk_i, .rst_ni, .ctrl_wr_i, .ctrl_wdata_i, .load_wr_i, .load_data_i, .rsel_wr_i,
  .dbg_halt0_i, .dbg_halt1_i, .jtag_busy_i, .count_o, .ctrl_o, .rst_req_o, .rsel_q
);

// File: tb/wdog_timer_test.sv
module wdog_timer_test;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        tick_wr = 0, tick_en = 0, ctrl_wr = 0, load_wr = 0, rsel_wr = 0;
  logic [7:0]  tick_cyc = 0;
  logic [4:0]  ctrl_wd = 0;
  logic [23:0] load_d = 0;
  logic [16:0] rsel_d = 0;
  logic        h0 = 0, h1 = 0, hj = 0;
  logic        tick_o;
  logic [23:0] count_o;
  logic [4:0]  ctrl_o;
  logic [16:0] rst_req_o;

  wdog_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_wr_i(tick_wr), .tick_en_i(tick_en), .tick_cycles_i(tick_cyc),
    .ctrl_wr_i(ctrl_wr), .ctrl_wdata_i(ctrl_wd), .load_wr_i(load_wr), .load_data_i(load_d),
    .rsel_wr_i(rsel_wr), .rsel_data_i(rsel_d), .dbg_halt0_i(h0), .dbg_halt1_i(h1), .jtag_busy_i(hj),
    .tick_o, .count_o, .ctrl_o, .rst_req_o
  );

  int vecs = 0, errs = 0;

  // reference model, built from the requirements
  logic        m_pen, m_tick, m_en, m_dec, m_exp;
  logic [7:0]  m_cyc, m_pc;
  logic [8:0]  m_inc;
  logic [2:0]  m_ps;
  logic [16:0] m_mask, m_req;
  logic [23:0] m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pen = 0; m_tick = 0; m_en = 0; m_cyc = 0; m_pc = 0;
      m_ps = 3'b111; m_mask = '1; m_req = 0; m_cnt = 0;
    end else begin
      m_dec = m_tick && m_en && !((m_ps[0] && h0) || (m_ps[1] && h1) || (m_ps[2] && hj)) && m_cnt != 0;
      m_exp = m_dec && m_cnt <= 2 && !load_wr;
      m_req = (m_exp || (ctrl_wr && ctrl_wd[4])) ? m_mask : '0;
      if (load_wr)    m_cnt = load_d;
      else if (m_dec) m_cnt = (m_cnt <= 2) ? 24'd0 : m_cnt - 24'd2;
      if (ctrl_wr) begin m_en = ctrl_wd[0]; m_ps = ctrl_wd[3:1]; end
      if (rsel_wr) m_mask = rsel_d;
      if (tick_wr) begin
        m_pen = tick_en; m_cyc = tick_cyc; m_pc = 0; m_tick = 0;
      end else if (!m_pen) begin
        m_pc = 0; m_tick = 0;
      end else begin
        m_inc = {1'b0, m_pc} + 9'd1;
        if (m_inc >= {1'b0, m_cyc}) begin m_pc = 0; m_tick = 1; end
        else begin m_pc = m_inc[7:0]; m_tick = 0; end
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vecs++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    check("R2", 32'(tick_o), 32'(m_tick));
    check("R4", 32'(count_o), 32'(m_cnt));
    check("R7", 32'(rst_req_o), 32'(m_req));
    check("R9", 32'(ctrl_o), {27'd0, 1'b0, m_ps, m_en});
  endtask

  task automatic wr_tick(input logic en, input logic [7:0] c);
    tick_wr = 1; tick_en = en; tick_cyc = c; cyc(); tick_wr = 0;
  endtask
  task automatic wr_ctrl(input logic [4:0] d);
    ctrl_wr = 1; ctrl_wd = d; cyc(); ctrl_wr = 0;
  endtask
  task automatic wr_load(input logic [23:0] d);
    load_wr = 1; load_d = d; cyc(); load_wr = 0;
  endtask
  task automatic wr_rsel(input logic [16:0] d);
    rsel_wr = 1; rsel_d = d; cyc(); rsel_wr = 0;
  endtask
  task automatic wait_req();
    for (int i = 0; i < 400; i++) begin
      cyc();
      if (rst_req_o != 0) break;
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    int nt;
    int r;
    logic [4:0] d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    cyc();
    // R1 reset state
    check("R1", 32'(ctrl_o), 32'h0E);
    check("R1", 32'(count_o), 0);
    check("R1", 32'(rst_req_o), 0);
    check("R1", 32'(tick_o), 0);
    // R3 prescaler off
    nt = 0;
    repeat (20) begin cyc(); nt += int'(tick_o); end
    check("R3", nt, 0);

    wr_tick(1'b1, 8'd4);
    wr_rsel(17'h1FFFC);
    wr_ctrl(5'b00001);
    wr_load(24'd10);
    check("R5", 32'(count_o), 10);
    wait_req();
    check("R10", 32'(rst_req_o), 32'h1FFFC);
    check("R7", 32'(count_o), 0);
    cyc();
    check("R7", 32'(rst_req_o), 0);
    repeat (12) cyc();
    check("R7", 32'(count_o), 0);
    // odd load: step from 1 saturates and expires
    wr_load(24'd5);
    wait_req();
    check("R7", 32'(rst_req_o), 32'h1FFFC);
    check("R7", 32'(count_o), 0);
    // pause on processor 0, then unrelated source active
    wr_ctrl(5'b00011);
    h0 = 1;
    wr_load(24'd100);
    repeat (20) cyc();
    check("R6", 32'(count_o), 100);
    h0 = 0; hj = 1;
    repeat (20) cyc();
    check("R6", 32'(count_o < 24'd100), 1);
    hj = 0;
    // trigger with enable cleared
    wr_ctrl(5'b10000);
    check("R8", 32'(rst_req_o), 32'h1FFFC);
    check("R9", 32'(ctrl_o), 0);
    wr_load(24'd50);
    repeat (20) cyc();
    check("R11", 32'(count_o), 50);
    wr_rsel(17'h00005);
    wr_ctrl(5'b10001);
    check("R10", 32'(rst_req_o), 32'h5);
    // load in the same cycle as a pending step to zero
    wr_tick(1'b1, 8'd1);
    wr_load(24'd2);
    wr_load(24'd30);
    check("R5", 32'(count_o), 30);
    check("R5", 32'(rst_req_o), 0);

    // constrained random
    for (int k = 0; k < 6000; k++) begin
      r = int'($urandom % 100);
      if (r < 4) begin
        load_wr = 1;
        load_d = ($urandom % 4 == 0) ? 24'($urandom) : 24'($urandom % 48);
      end else if (r < 7) begin
        d = 5'($urandom);
        if (d[4] && ($urandom % 3 != 0)) d[4] = 1'b0;
        ctrl_wr = 1; ctrl_wd = d;
      end else if (r < 9) begin
        tick_wr = 1; tick_en = ($urandom % 5 != 0); tick_cyc = 8'($urandom % 6);
      end else if (r < 10) begin
        rsel_wr = 1; rsel_d = 17'($urandom);
      end
      if ($urandom % 16 == 0) h0 = ~h0;
      if ($urandom % 16 == 0) h1 = ~h1;
      if ($urandom % 16 == 0) hj = ~hj;
      cyc();
      load_wr = 0; ctrl_wr = 0; tick_wr = 0; rsel_wr = 0;
    end
    summary();
  end
endmodule